// File: doc/BRIEF.md
# Branch and Call Target Unit

This block decides where a 32-bit machine with word-aligned instructions fetches next. Each cycle it looks at the current program counter, the instruction word and the two source register values that the register file has already read for that instruction, and produces the next program counter. It also raises a taken flag, and it raises a link write request for call instructions. Conditional branches compare the two source operands and jump by a scaled 16-bit offset. Immediate jumps and calls move by a scaled 26-bit offset. Register-indirect jumps and calls go to the first source value.

The program counter lives in a register inside the block and advances only when the step enable is high. A register-indirect jump through register 29, 30 or 31 is reported as a return, an exception return or a breakpoint return, so the surrounding pipeline can act on it. A target with nonzero low bits sets a misalignment flag, and the stored counter always keeps those two bits clear.

Top module: `pcr_top`

## Requirements
- R1: While reset is asserted and after it is released, and before the first step, `pc_q` equals the parameter RESET_VEC with its two low bits cleared. The default value is 0x0000_1000.
- R2: Some opcodes (`instr[31:26]`) are not control transfers. One example is 45. For such an opcode, `taken` is 0, `next_pc` is `pc_q`+4 and `link_we` is 0.
- R3: Opcodes 17 (equal) and 23 (not equal) compare `src_a` with `src_b`. When the condition holds, `taken` is 1 and `next_pc` is `pc_q` plus the sign-extended `instr[15:0]` shifted left by 2. When it does not hold, `taken` is 0 and `next_pc` is `pc_q`+4.
- R4: Some conditional opcodes compare `src_a` against `src_b` as signed values: 18 (greater) and 19 (greater or equal). Others compare them as unsigned values: 21 (greater) and 20 (greater or equal).
- R5: Opcodes 56 (jump) and 62 (call) are always taken. For both, `next_pc` is `pc_q` plus the sign-extended `instr[25:0]` shifted left by 2.
- R6: Opcodes 48 (jump) and 54 (call) are always taken, and for both `next_pc` is `src_a` with its two low bits cleared.
- R7: For opcode 54 or 62 with `step_en` high, `link_we` is 1, `link_idx` is 29 and `link_data` is `pc_q`+4. In every other case `link_we` is 0.
- R8: `ret_kind` reports the kind of return. For opcode 48 with `instr[25:21]` equal to 29 it is 1 (return), to 30 it is 2 (exception return), and to 31 it is 3 (breakpoint return). Otherwise it is 0.
- R9: `misaligned` is 1 exactly when a taken target has nonzero low two bits. `next_pc[1:0]` and `pc_q[1:0]` are always 0.
- R10: At a clock edge with `step_en` high, `pc_q` loads `next_pc`. With `step_en` low, `pc_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance the program counter this cycle |
| instr | input | 32 | Instruction word at `pc_q` |
| src_a | input | 32 | Value of the register named in bits 25..21 |
| src_b | input | 32 | Value of the register named in bits 20..16 |
| pc_q | output | 32 | Current program counter |
| next_pc | output | 32 | Computed next program counter |
| taken | output | 1 | Control transfer taken |
| misaligned | output | 1 | Taken target had nonzero low bits |
| link_we | output | 1 | Link register write request |
| link_idx | output | 5 | Link register index (29) |
| link_data | output | 32 | Return address, `pc_q`+4 |
| ret_kind | output | 2 | 0 none, 1 return, 2 exception return, 3 breakpoint return |

## Verification
The comparison is driven with operand pairs that are equal, and with pairs whose signed and unsigned orderings disagree, such as 0xFFFFFFFF against 1. A unit that confuses signed with unsigned compares, or the strict test with the inclusive one, then picks the wrong direction. Forward and backward offsets are applied to both the 16-bit and the 26-bit forms, which exposes a missing sign extension or a missing scale by 4. The indirect jumps are tried through ordinary registers and through registers 29, 30 and 31, and with a deliberately unaligned target. Calls are issued with the step enable both high and low, which separates the link request from the hold behaviour.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

  localparam int unsigned OPW = 6;

  localparam logic [OPW-1:0] OPC_BEQ   = 6'd17;
  localparam logic [OPW-1:0] OPC_BGTS  = 6'd18;
  localparam logic [OPW-1:0] OPC_BGES  = 6'd19;
  localparam logic [OPW-1:0] OPC_BGEU  = 6'd20;
  localparam logic [OPW-1:0] OPC_BGTU  = 6'd21;
  localparam logic [OPW-1:0] OPC_BNEQ  = 6'd23;
  localparam logic [OPW-1:0] OPC_JREG  = 6'd48;
  localparam logic [OPW-1:0] OPC_CREG  = 6'd54;
  localparam logic [OPW-1:0] OPC_JREL  = 6'd56;
  localparam logic [OPW-1:0] OPC_CREL  = 6'd62;

  typedef enum logic [1:0] {
    XK_NONE  = 2'd0,
    XK_COND  = 2'd1,
    XK_REL26 = 2'd2,
    XK_REG   = 2'd3
  } xfer_kind_e;

  typedef enum logic [2:0] {
    CD_EQ  = 3'd0,
    CD_NE  = 3'd1,
    CD_GTS = 3'd2,
    CD_GES = 3'd3,
    CD_GTU = 3'd4,
    CD_GEU = 3'd5
  } cond_e;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_FUNC = 2'd1,
    RK_EXC  = 2'd2,
    RK_BRK  = 2'd3
  } ret_kind_e;

  typedef struct packed {
    xfer_kind_e kind;
    cond_e      cond;
    logic       link;
    ret_kind_e  ret;
  } xfer_dec_t;

endpackage

// File: rtl/pcr_decode.sv
module pcr_decode
  import pcr_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [OPW-1:0]    opcode,
  input  logic [REG_AW-1:0] ra_idx,
  output xfer_dec_t         dec
);

  localparam logic [REG_AW-1:0] IDX_RA = REG_AW'(29);
  localparam logic [REG_AW-1:0] IDX_EA = REG_AW'(30);
  localparam logic [REG_AW-1:0] IDX_BA = REG_AW'(31);

  always_comb begin
    dec.kind = XK_NONE;
    dec.cond = CD_EQ;
    dec.link = 1'b0;
    dec.ret  = RK_NONE;
    unique case (opcode)
      OPC_BEQ:  begin dec.kind = XK_COND; dec.cond = CD_EQ;  end
      OPC_BNEQ: begin dec.kind = XK_COND; dec.cond = CD_NE;  end
      OPC_BGTS: begin dec.kind = XK_COND; dec.cond = CD_GTS; end
      OPC_BGES: begin dec.kind = XK_COND; dec.cond = CD_GES; end
      OPC_BGTU: begin dec.kind = XK_COND; dec.cond = CD_GTU; end
      OPC_BGEU: begin dec.kind = XK_COND; dec.cond = CD_GEU; end
      OPC_JREL: dec.kind = XK_REL26;
      OPC_CREL: begin dec.kind = XK_REL26; dec.link = 1'b1; end
      OPC_CREG: begin dec.kind = XK_REG;   dec.link = 1'b1; end
      OPC_JREG: begin
        dec.kind = XK_REG;
        if (ra_idx == IDX_RA)      dec.ret = RK_FUNC;
        else if (ra_idx == IDX_EA) dec.ret = RK_EXC;
        else if (ra_idx == IDX_BA) dec.ret = RK_BRK;
        else                       dec.ret = RK_NONE;
      end
      default: dec.kind = XK_NONE;
    endcase
  end

endmodule

// File: rtl/pcr_cmp.sv
module pcr_cmp
  import pcr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  cond_e           cond,
  output logic            hit
);

  logic eq_w, gts_w, gtu_w;

  always_comb begin
    eq_w  = (op_a == op_b);
    gts_w = ($signed(op_a) > $signed(op_b));
    gtu_w = (op_a > op_b);
    unique case (cond)
      CD_EQ:   hit = eq_w;
      CD_NE:   hit = !eq_w;
      CD_GTS:  hit = gts_w;
      CD_GES:  hit = gts_w | eq_w;
      CD_GTU:  hit = gtu_w;
      CD_GEU:  hit = gtu_w | eq_w;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pcr_target.sv
module pcr_target
  import pcr_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFF_S = 16,
  parameter int unsigned OFF_L = 26
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [OFF_L-1:0] off_field,
  input  logic [XLEN-1:0]  reg_val,
  input  xfer_kind_e       kind,
  output logic [XLEN-1:0]  target,
  output logic [XLEN-1:0]  seq_pc
);

  localparam int unsigned EXT_S = XLEN - OFF_S - 2;
  localparam int unsigned EXT_L = XLEN - OFF_L - 2;

  logic [XLEN-1:0] disp_s, disp_l;

  always_comb begin
    disp_s = {{EXT_S{off_field[OFF_S-1]}}, off_field[OFF_S-1:0], 2'b00};
    disp_l = {{EXT_L{off_field[OFF_L-1]}}, off_field, 2'b00};
    seq_pc = pc + XLEN'(4);
    unique case (kind)
      XK_COND:  target = pc + disp_s;
      XK_REL26: target = pc + disp_l;
      XK_REG:   target = reg_val;
      default:  target = seq_pc;
    endcase
  end

endmodule

// File: rtl/pcr_top.sv
module pcr_top
  import pcr_pkg::*;
#(
  parameter int unsigned   XLEN      = 32,
  parameter int unsigned   REG_AW    = 5,
  parameter int unsigned   LINK_REG  = 29,
  parameter logic [31:0]   RESET_VEC = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [XLEN-1:0]   instr,
  input  logic [XLEN-1:0]   src_a,
  input  logic [XLEN-1:0]   src_b,
  output logic [XLEN-1:0]   pc_q,
  output logic [XLEN-1:0]   next_pc,
  output logic              taken,
  output logic              misaligned,
  output logic              link_we,
  output logic [REG_AW-1:0] link_idx,
  output logic [XLEN-1:0]   link_data,
  output logic [1:0]        ret_kind
);

  localparam int unsigned     OFF_L     = 26;
  localparam logic [XLEN-1:0] RST_ALIGN = {RESET_VEC[XLEN-1:2], 2'b00};

  xfer_dec_t       dec;
  logic            cond_hit;
  logic [XLEN-1:0] target, seq_pc, raw_pc, pc_d;

  pcr_decode #(.REG_AW(REG_AW)) u_dec (
    .opcode (instr[XLEN-1:XLEN-OPW]),
    .ra_idx (instr[OFF_L-1:OFF_L-REG_AW]),
    .dec    (dec)
  );

  pcr_cmp #(.XLEN(XLEN)) u_cmp (
    .op_a (src_a),
    .op_b (src_b),
    .cond (dec.cond),
    .hit  (cond_hit)
  );

  pcr_target #(.XLEN(XLEN), .OFF_S(16), .OFF_L(OFF_L)) u_tgt (
    .pc        (pc_q),
    .off_field (instr[OFF_L-1:0]),
    .reg_val   (src_a),
    .kind      (dec.kind),
    .target    (target),
    .seq_pc    (seq_pc)
  );

  always_comb begin
    unique case (dec.kind)
      XK_COND: taken = cond_hit;
      XK_NONE: taken = 1'b0;
      default: taken = 1'b1;
    endcase
    raw_pc     = taken ? target : seq_pc;
    misaligned = taken && (raw_pc[1:0] != 2'b00);
    next_pc    = {raw_pc[XLEN-1:2], 2'b00};
    link_we    = step_en && dec.link;
    link_idx   = REG_AW'(LINK_REG);
    link_data  = seq_pc;
    ret_kind   = dec.ret;
    pc_d       = step_en ? next_pc : pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RST_ALIGN;
    else        pc_q <= pc_d;
  end

endmodule

// File: rtl/pcr_checker.sv
module pcr_checker #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_en,
  input logic [XLEN-1:0]   src_a,
  input logic [XLEN-1:0]   pc_q,
  input logic [XLEN-1:0]   next_pc,
  input logic              taken,
  input logic              link_we,
  input logic [REG_AW-1:0] link_idx,
  input logic [XLEN-1:0]   link_data,
  input logic [1:0]        ret_kind
);

  p_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> next_pc == pc_q + XLEN'(4));

  p_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (link_idx == REG_AW'(29) && link_data == pc_q + XLEN'(4) && taken && step_en));

  p_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_kind != 2'd0) |-> (taken && !link_we && next_pc == {src_a[XLEN-1:2], 2'b00}));

  p_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[1:0] == 2'b00);

  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> pc_q == $past(next_pc));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(pc_q));

endmodule

bind pcr_top pcr_checker #(.XLEN(XLEN), .REG_AW(REG_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step_en   (step_en),
  .src_a     (src_a),
  .pc_q      (pc_q),
  .next_pc   (next_pc),
  .taken     (taken),
  .link_we   (link_we),
  .link_idx  (link_idx),
  .link_data (link_data),
  .ret_kind  (ret_kind)
);

// File: tb/pcr_top_tb.sv
`timescale 1ns/1ps
module pcr_top_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_en;
  logic [31:0] instr, src_a, src_b;
  logic [31:0] pc_q, next_pc, link_data;
  logic        taken, misaligned, link_we;
  logic [4:0]  link_idx;
  logic [1:0]  ret_kind;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pcr_top u_dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .instr(instr),
    .src_a(src_a), .src_b(src_b), .pc_q(pc_q), .next_pc(next_pc),
    .taken(taken), .misaligned(misaligned), .link_we(link_we),
    .link_idx(link_idx), .link_data(link_data), .ret_kind(ret_kind)
  );

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] ra,
                                        input logic [4:0] rb, input logic [15:0] imm);
    return {op, ra, rb, imm};
  endfunction

  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] off);
    return {op, off};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b,
                       input logic en);
    @(negedge clk);
    instr = i; src_a = a; src_b = b; step_en = en;
    #1;
  endtask

  task automatic goto_pc(input logic [31:0] addr);
    apply(enc_i(6'd48, 5'd3, 5'd0, 16'd0), addr, 32'd0, 1'b1);
    apply(32'd0, 32'd0, 32'd0, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 pc after reset", pc_q, 32'h0000_1000);
  endtask

  task automatic t_seq;
    logic [31:0] p;
    p = pc_q;
    apply(enc_i(6'd45, 5'd1, 5'd2, 16'h0000), 32'h5, 32'h5, 1'b1);
    chk("R2 next pc", next_pc, p + 4);
    chk("R2 taken", {31'd0, taken}, 32'd0);
    chk("R2 link", {31'd0, link_we}, 32'd0);
    apply(32'd0, 32'd0, 32'd0, 1'b0);
    chk("R10 step loads", pc_q, p + 4);
  endtask

  task automatic t_cond;
    goto_pc(32'h0000_4000);
    apply(enc_i(6'd17, 5'd1, 5'd2, 16'hFFF0), 32'h77, 32'h77, 1'b0);
    chk("R3 beq taken", {31'd0, taken}, 32'd1);
    chk("R3 beq back", next_pc, 32'h0000_3FC0);
    apply(enc_i(6'd23, 5'd1, 5'd2, 16'h0010), 32'h77, 32'h77, 1'b0);
    chk("R3 bne not", next_pc, 32'h0000_4004);
    apply(enc_i(6'd23, 5'd1, 5'd2, 16'h0010), 32'h77, 32'h78, 1'b0);
    chk("R3 bne fwd", next_pc, 32'h0000_4040);
  endtask

  task automatic t_sign;
    apply(enc_i(6'd18, 5'd1, 5'd2, 16'h0004), 32'hFFFF_FFFF, 32'h1, 1'b0);
    chk("R4 bgs neg", {31'd0, taken}, 32'd0);
    apply(enc_i(6'd21, 5'd1, 5'd2, 16'h0004), 32'hFFFF_FFFF, 32'h1, 1'b0);
    chk("R4 bgu big", {31'd0, taken}, 32'd1);
    chk("R4 bgu tgt", next_pc, 32'h0000_4010);
    apply(enc_i(6'd19, 5'd1, 5'd2, 16'h0004), 32'h8000_0000, 32'h8000_0000, 1'b0);
    chk("R4 bges eq", {31'd0, taken}, 32'd1);
    apply(enc_i(6'd18, 5'd1, 5'd2, 16'h0004), 32'h8000_0000, 32'h8000_0000, 1'b0);
    chk("R4 bgs eq", {31'd0, taken}, 32'd0);
    apply(enc_i(6'd20, 5'd1, 5'd2, 16'h0004), 32'h1, 32'hFFFF_FFFF, 1'b0);
    chk("R4 bgeu small", {31'd0, taken}, 32'd0);
    apply(enc_i(6'd19, 5'd1, 5'd2, 16'h0004), 32'h1, 32'hFFFF_FFFF, 1'b0);
    chk("R4 bges pos", {31'd0, taken}, 32'd1);
  endtask

  task automatic t_rel26;
    apply(enc_j(6'd56, 26'h3FF_FF00), 32'd0, 32'd0, 1'b0);
    chk("R5 jump back", next_pc, 32'h0000_3C00);
    chk("R7 jump no link", {31'd0, link_we}, 32'd0);
    apply(enc_j(6'd62, 26'h010_0000), 32'd0, 32'd0, 1'b1);
    chk("R5 call fwd", next_pc, 32'h0040_4000);
    chk("R7 call link we", {31'd0, link_we}, 32'd1);
    chk("R7 call idx", {27'd0, link_idx}, 32'd29);
    chk("R7 call data", link_data, 32'h0000_4004);
    apply(32'd0, 32'd0, 32'd0, 1'b0);
    chk("R10 pc after call", pc_q, 32'h0040_4000);
  endtask

  task automatic t_reg;
    apply(enc_i(6'd54, 5'd7, 5'd0, 16'd0), 32'h0000_8000, 32'd0, 1'b1);
    chk("R6 call reg", next_pc, 32'h0000_8000);
    chk("R7 creg data", link_data, 32'h0040_4004);
    chk("R8 creg none", {30'd0, ret_kind}, 32'd0);
    apply(enc_i(6'd48, 5'd29, 5'd0, 16'd0), 32'h0000_0100, 32'd0, 1'b0);
    chk("R8 ret", {30'd0, ret_kind}, 32'd1);
    chk("R6 ret tgt", next_pc, 32'h0000_0100);
    apply(enc_i(6'd48, 5'd30, 5'd0, 16'd0), 32'h0000_0100, 32'd0, 1'b0);
    chk("R8 eret", {30'd0, ret_kind}, 32'd2);
    apply(enc_i(6'd48, 5'd31, 5'd0, 16'd0), 32'h0000_0100, 32'd0, 1'b0);
    chk("R8 bret", {30'd0, ret_kind}, 32'd3);
    apply(enc_i(6'd48, 5'd28, 5'd0, 16'd0), 32'h0000_0100, 32'd0, 1'b0);
    chk("R8 plain jump", {30'd0, ret_kind}, 32'd0);
  endtask

  task automatic t_misalign;
    apply(enc_i(6'd48, 5'd4, 5'd0, 16'd0), 32'h0000_2003, 32'd0, 1'b1);
    chk("R9 flag", {31'd0, misaligned}, 32'd1);
    chk("R9 next low", next_pc, 32'h0000_2000);
    apply(enc_i(6'd48, 5'd4, 5'd0, 16'd0), 32'h0000_2004, 32'd0, 1'b0);
    chk("R9 pc low", pc_q, 32'h0000_2000);
    chk("R9 aligned flag", {31'd0, misaligned}, 32'd0);
  endtask

  task automatic t_hold;
    apply(enc_j(6'd62, 26'h000_0040), 32'd0, 32'd0, 1'b0);
    chk("R7 no step no link", {31'd0, link_we}, 32'd0);
    apply(32'd0, 32'd0, 32'd0, 1'b0);
    chk("R10 hold", pc_q, 32'h0000_2000);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; step_en = 1'b0; instr = '0; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    t_reset();
    t_seq();
    t_cond();
    t_sign();
    t_rel26();
    t_reg();
    t_misalign();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule